// File: doc/BRIEF.md
# CAN Controller Interrupt Aggregator

This block gathers the eight interrupt sources of a CAN controller into one pending-flag byte. The sources are message error, wake-up, error-state change, three transmit-slot-empty events and two receive-slot-full events. Each source arrives as a one-cycle strobe. The error source has two triggers: a direct strobe, and any change in a vector of error-state conditions, which the block watches itself. A flag stays pending until the host clears it.

A host-writable enable byte selects which pending flags may interrupt. The block drives an active-low interrupt request while any enabled flag is pending. It also reports a 3-bit code naming the most urgent enabled pending source. The host reads the code, services that source and clears its flag with a bit-mask write.

Top module: `can_irq_unit`

## Requirements
- R1: After reset, the flag byte and the enable byte read 0, the interrupt request is high (inactive) and the code reads 000.
- R2: A strobe on `evt_i[k]` sets flag bit k on the next clock edge. The bit positions are: 7 message error, 6 wake-up, 5 error, 4 TX slot 2 empty, 3 TX slot 1 empty, 2 TX slot 0 empty, 1 RX slot 1 full, 0 RX slot 0 full. The enable byte uses the same positions.
- R3: A set flag stays set until a clear write (`clr_we`=1) has a 1 in its position in `clr_mask`. A clear write leaves the flags at 0 positions of `clr_mask` unchanged.
- R4: When a strobe and a clear hit the same flag in the same cycle, the flag is set after the edge.
- R5: A flag latches its strobe even when its enable bit is 0.
- R6: `irq_n_o` is 0 exactly when some flag bit and the enable bit in the same position are both 1.
- R7: The code for each enabled pending source alone is: error 001, wake-up 010, TX slot 0 011, TX slot 1 100, TX slot 2 101, RX slot 0 110, RX slot 1 111. The code is 000 when none of these is pending and enabled.
- R8: When several enabled flags are pending, the code reports the one with the smallest nonzero code value. Disabled flags are skipped.
- R9: The message-error flag has no code. Alone, it leaves the code at 000, but it still drives `irq_n_o` low when enabled.
- R10: Any change of `err_cond_i` from its value in the previous cycle sets the error flag (bit 5) on the next edge. After reset the previous value counts as 0. An unchanged vector sets nothing.
- R11: A write with `en_we`=1 loads `en_wdata` into the enable byte. The new value appears on `en_o` after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 8 | One strobe per source, bit order as in R2 |
| err_cond_i | input | 8 | Error-state condition vector; any change raises the error flag |
| en_we | input | 1 | Enable byte write strobe |
| en_wdata | input | 8 | Enable byte write data |
| clr_we | input | 1 | Flag clear strobe |
| clr_mask | input | 8 | Flags to clear, 1 = clear |
| en_o | output | 8 | Enable byte |
| flags_o | output | 8 | Pending flag byte |
| irq_n_o | output | 1 | Interrupt request, active low |
| code_o | output | 3 | Code of the most urgent enabled pending source |

## Verification
The hardest case to reach is a strobe and a clear landing on the same bit in one edge, mixed with clears on other bits. The bench drives both in one cycle, with masks that overlap and masks that do not. A second hard case is a change-triggered error flag racing its own clear. The bench first clears the flag with the condition vector held steady, to show that nothing new is raised. It then toggles the vector back to raise the flag again. Priority is exercised by layering several pending sources, then disabling the winner so the code must fall to the next one.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
    localparam int NSRC   = 8;
    localparam int CODE_W = 3;
    localparam int ERR_W  = 8;

    localparam int SRC_RX0  = 0;
    localparam int SRC_RX1  = 1;
    localparam int SRC_TX0  = 2;
    localparam int SRC_TX1  = 3;
    localparam int SRC_TX2  = 4;
    localparam int SRC_ERR  = 5;
    localparam int SRC_WAKE = 6;
    localparam int SRC_MERR = 7;

    typedef struct packed {
        logic [NSRC-1:0] flags;
        logic [NSRC-1:0] en;
    } irq_state_t;

    // Fixed code per source position; 0 means the source has no code.
    function automatic logic [CODE_W-1:0] code_of(input int src);
        case (src)
            SRC_ERR:  code_of = 3'd1;
            SRC_WAKE: code_of = 3'd2;
            SRC_TX0:  code_of = 3'd3;
            SRC_TX1:  code_of = 3'd4;
            SRC_TX2:  code_of = 3'd5;
            SRC_RX0:  code_of = 3'd6;
            SRC_RX1:  code_of = 3'd7;
            default:  code_of = 3'd0;
        endcase
    endfunction
endpackage

// File: rtl/can_irq_errdet.sv
module can_irq_errdet #(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] cond_i,
    output logic             change_o
);
    logic [ERR_W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d   = cond_i;
        change_o = (cond_i != prev_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/can_irq_prio.sv
module can_irq_prio
    import can_irq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0]      pend_i,
    output logic [CODE_W-1:0] code_o,
    output logic              any_o
);
    always_comb begin
        code_o = '0;
        any_o  = |pend_i;
        for (int b = 0; b < N; b++) begin
            if (pend_i[b] && code_of(b) != '0 &&
                (code_o == '0 || code_of(b) < code_o)) begin
                code_o = code_of(b);
            end
        end
    end
endmodule

// File: rtl/can_irq_unit.sv
module can_irq_unit
    import can_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   evt_i,
    input  logic [ERR_W-1:0]  err_cond_i,
    input  logic              en_we,
    input  logic [NSRC-1:0]   en_wdata,
    input  logic              clr_we,
    input  logic [NSRC-1:0]   clr_mask,
    output logic [NSRC-1:0]   en_o,
    output logic [NSRC-1:0]   flags_o,
    output logic              irq_n_o,
    output logic [CODE_W-1:0] code_o
);
    irq_state_t      st_d, st_q;
    logic            err_change;
    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] pend;
    logic            pend_any;

    can_irq_errdet #(.ERR_W(ERR_W)) u_errdet (
        .clk      (clk),
        .rst_n    (rst_n),
        .cond_i   (err_cond_i),
        .change_o (err_change)
    );

    always_comb begin
        set_vec          = evt_i;
        set_vec[SRC_ERR] = evt_i[SRC_ERR] | err_change;

        st_d = st_q;
        if (en_we)  st_d.en    = en_wdata;
        if (clr_we) st_d.flags = st_q.flags & ~clr_mask;
        st_d.flags = st_d.flags | set_vec;   // set beats clear

        pend = st_q.flags & st_q.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    can_irq_prio #(.N(NSRC)) u_prio (
        .pend_i (pend),
        .code_o (code_o),
        .any_o  (pend_any)
    );

    assign en_o    = st_q.en;
    assign flags_o = st_q.flags;
    assign irq_n_o = ~pend_any;
endmodule

// File: rtl/can_irq_unit_chk.sv
module can_irq_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] evt_i,
    input logic       en_we,
    input logic [7:0] en_wdata,
    input logic       clr_we,
    input logic [7:0] en_o,
    input logic [7:0] flags_o,
    input logic       irq_n_o,
    input logic [2:0] code_o
);
    assert_irq_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n_o == ((flags_o & en_o) == 8'h00));

    assert_flag_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != 8'h00) |=> ((flags_o & $past(evt_i)) == $past(evt_i)));

    assert_code_none_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o == 3'd0) |-> ((flags_o & en_o & 8'h7F) == 8'h00));

    assert_code_some_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o != 3'd0) |-> !irq_n_o);

    assert_en_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        en_we |=> (en_o == $past(en_wdata)));
endmodule

bind can_irq_unit can_irq_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_i),
    .en_we    (en_we),
    .en_wdata (en_wdata),
    .clr_we   (clr_we),
    .en_o     (en_o),
    .flags_o  (flags_o),
    .irq_n_o  (irq_n_o),
    .code_o   (code_o)
);

// File: tb/tb_can_irq_unit.sv
module tb_can_irq_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] evt_i = '0;
    logic [7:0] err_cond_i = '0;
    logic       en_we = 1'b0;
    logic [7:0] en_wdata = '0;
    logic       clr_we = 1'b0;
    logic [7:0] clr_mask = '0;
    logic [7:0] en_o, flags_o;
    logic       irq_n_o;
    logic [2:0] code_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    can_irq_unit dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .err_cond_i(err_cond_i),
        .en_we(en_we), .en_wdata(en_wdata), .clr_we(clr_we), .clr_mask(clr_mask),
        .en_o(en_o), .flags_o(flags_o), .irq_n_o(irq_n_o), .code_o(code_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Independent model of R7/R8: walk sources in urgency order.
    function automatic logic [2:0] exp_code(input logic [7:0] p);
        int order [7] = '{5, 6, 2, 3, 4, 0, 1};
        logic [2:0] codes [7] = '{3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
        for (int i = 0; i < 7; i++) if (p[order[i]]) return codes[i];
        return 3'd0;
    endfunction

    // Drive one cycle of stimulus on the falling edge, sample on the next falling edge.
    task automatic cycle(input logic [7:0] ev, input logic cw, input logic [7:0] cm);
        evt_i = ev; clr_we = cw; clr_mask = cm;
        @(negedge clk);
        evt_i = '0; clr_we = 1'b0; clr_mask = '0;
    endtask

    task automatic write_en(input logic [7:0] v);
        en_we = 1'b1; en_wdata = v;
        @(negedge clk);
        en_we = 1'b0;
    endtask

    task automatic clear_all();
        cycle(8'h00, 1'b1, 8'hFF);
    endtask

    task automatic t_reset();
        check("R1 flags", flags_o, 8'h00);
        check("R1 en", en_o, 8'h00);
        check("R1 irq_n", {7'd0, irq_n_o}, 8'h01);
        check("R1 code", {5'd0, code_o}, 8'h00);
    endtask

    task automatic t_enable_rb();
        write_en(8'hA5);
        check("R11 en readback", en_o, 8'hA5);
        write_en(8'h00);
        check("R11 en zero", en_o, 8'h00);
    endtask

    task automatic t_set_each();
        for (int k = 0; k < 8; k++) begin
            cycle(8'h01 << k, 1'b0, 8'h00);
            check("R2 single set", flags_o, 8'h01 << k);
            check("R5 disabled no irq", {7'd0, irq_n_o}, 8'h01);
            clear_all();
        end
    endtask

    task automatic t_clear_mask();
        cycle(8'hFF, 1'b0, 8'h00);
        cycle(8'h00, 1'b0, 8'h00);
        check("R3 persist", flags_o, 8'hFF);
        cycle(8'h00, 1'b1, 8'h3C);
        check("R3 partial clear", flags_o, 8'hC3);
        clear_all();
        check("R3 full clear", flags_o, 8'h00);
    endtask

    task automatic t_evt_vs_clear();
        cycle(8'h0F, 1'b0, 8'h00);
        cycle(8'h05, 1'b1, 8'h0F);
        check("R4 event wins", flags_o, 8'h05);
        cycle(8'h80, 1'b1, 8'h05);
        check("R4 other bits", flags_o, 8'h80);
        clear_all();
    endtask

    task automatic t_priority();
        logic [7:0] pats [6] = '{8'h7F, 8'h5F, 8'h1E, 8'h03, 8'h02, 8'h10};
        write_en(8'hFF);
        for (int i = 0; i < 6; i++) begin
            cycle(pats[i], 1'b0, 8'h00);
            check("R8 code", {5'd0, code_o}, {5'd0, exp_code(pats[i])});
            check("R6 irq low", {7'd0, irq_n_o}, 8'h00);
            clear_all();
        end
        for (int k = 0; k < 7; k++) begin
            cycle(8'h01 << k, 1'b0, 8'h00);
            check("R7 single code", {5'd0, code_o}, {5'd0, exp_code(8'h01 << k)});
            clear_all();
        end
        cycle(8'h64, 1'b0, 8'h00);
        write_en(8'hDF);
        check("R8 disabled skip", {5'd0, code_o}, 8'h02);
        write_en(8'h9B);
        check("R6 none enabled", {7'd0, irq_n_o}, 8'h01);
        check("R5 flags kept", flags_o, 8'h64);
        clear_all();
    endtask

    task automatic t_merr();
        write_en(8'h80);
        cycle(8'h80, 1'b0, 8'h00);
        check("R9 code none", {5'd0, code_o}, 8'h00);
        check("R9 irq low", {7'd0, irq_n_o}, 8'h00);
        write_en(8'hFF);
        cycle(8'h02, 1'b0, 8'h00);
        check("R9 no effect on code", {5'd0, code_o}, 8'h07);
        clear_all();
    endtask

    task automatic t_errchange();
        err_cond_i = 8'h01;
        @(negedge clk);
        check("R10 change sets", flags_o, 8'h20);
        clear_all();
        cycle(8'h00, 1'b0, 8'h00);
        check("R10 steady no set", flags_o, 8'h00);
        err_cond_i = 8'h00;
        @(negedge clk);
        check("R10 change back", flags_o, 8'h20);
        check("R10 code", {5'd0, code_o}, 8'h01);
        clear_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable_rb();
        t_set_each();
        t_clear_mask();
        t_evt_vs_clear();
        t_priority();
        t_merr();
        t_errchange();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule